// File: doc/BRIEF.md
# SoC Power Mode Controller

This block moves a small system-on-chip between its run state and three low-power states: sleep, stop and standby. While the chip is running, software selects a target low-power state and then pulses an entry strobe, which takes the place of a wait-for-interrupt instruction. The controller then drives the clock, oscillator and core-power enable outputs for the chosen state.

For stop, the controller picks one of two depths by itself. The light depth is used whenever a peripheral still needs a clock. Otherwise the deep depth is used, with every bus and kernel clock off. Standby is granted only while the radio link layer reports deep sleep. If it does not, the controller falls back to stop and sets a sticky flag to record the downgrade.

Each wake-up source is a level input and is masked according to the state the chip is in. An unmasked source returns the chip to run and is recorded as the wake cause. On that return the controller also states which clock source to use, and it issues a reset request when the chip leaves standby. Regulators, oscillators and memory retention are modelled only as enable outputs and status inputs.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is run (code 0), every enable output is high, and the retention outputs, downgrade flag, wake cause, reset request and internal-clock flag are all zero.
- R2: In run, an entry strobe with a requested mode of 1 (sleep), 2 (stop) or 3 (standby) sets the mode one cycle later. A requested mode of 0 is ignored, and so is any strobe given while not in run.
- R3: Entering stop selects the light depth (stop_deep=0) when any kernel-clock request or autonomous-bus request is high at entry. Otherwise it selects the deep depth (stop_deep=1).
- R4: A standby request is granted only when ll_deep_sleep is high. Otherwise the controller enters stop and sets the downgrade flag.
- R5: Wake bits are: 0 interrupt/event, 1 external line, 2 autonomous peripheral, 3 radio sleep timer, 4 watchdog, 5 RTC, 6 tamper, 7 wake pin, 8 external reset, 9 brown-out, 10 clock-security. In sleep, all bits are allowed. In stop, all bits except 0 are allowed, and bit 10 is allowed only at the light depth. In standby, bits 4 to 9 are allowed, and bit 3 is allowed only when radio retention was requested at entry.
- R6: When any allowed wake bit is high in a low-power mode, the mode is run one cycle later and wake_cause holds the allowed bits that were high. Wake bits that are not allowed leave the mode unchanged.
- R7: On a wake from stop or standby, wake_clk_hsi becomes 1, selecting the 16 MHz internal oscillator. On a wake from sleep it becomes 0, meaning the clock in use before entry is kept.
- R8: reset_req is a single-cycle pulse, issued together with the return to run, only on a wake from standby.
- R9: The enables {cpu, sys, hs_osc, bus, core} are 11111 in run, 01111 in sleep, 00011 in light stop, 00001 in deep stop and 00000 in standby.
- R10: sram_ret and radio_ret carry the retention requests captured at entry while the mode is standby, and are zero in every other mode.
- R11: The downgrade flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_enter | input | 1 | Entry strobe (wait-for-interrupt stand-in) |
| lp_req | input | 2 | Requested mode: 1 sleep, 2 stop, 3 standby |
| lp_keep_sram | input | 2 | Standby SRAM bank retention requests |
| lp_keep_radio | input | 1 | Standby radio timer/RAM retention request |
| kern_clk_req | input | N_KER | Peripheral kernel-clock requests |
| auto_bus_req | input | N_AUTO | Autonomous-peripheral bus-clock requests |
| ll_deep_sleep | input | 1 | Link layer is in deep sleep |
| wake_src | input | 11 | Wake-up source levels (bits per R5) |
| mode | output | 2 | Current mode: 0 run, 1 sleep, 2 stop, 3 standby |
| stop_deep | output | 1 | High in stop at the deep depth |
| cpu_clk_en | output | 1 | CPU clock enable |
| sys_clk_en | output | 1 | System clock enable |
| hs_osc_en | output | 1 | High-speed oscillator enable |
| bus_clk_en | output | 1 | Bus/kernel clock enable |
| core_pwr_en | output | 1 | Core domain regulator enable |
| sram_ret | output | 2 | SRAM bank retention enables |
| radio_ret | output | 1 | Radio timer/RAM retention enable |
| downgrade | output | 1 | Sticky: standby was refused |
| wake_cause | output | 11 | Allowed wake bits seen at the last wake |
| wake_clk_hsi | output | 1 | Use the 16 MHz internal oscillator after wake |
| reset_req | output | 1 | Reset request pulse on leaving standby |

## Verification
Two functions can fall in the same cycle: refusing standby and waking up. The bench requests standby while the link layer is awake and holds the radio sleep-timer wake bit high in that same entry cycle. The controller must land in stop with the downgrade flag set, leave on the very next cycle because that bit is allowed in stop, select the internal oscillator and issue no reset. A second case holds a wake bit high across entry, and random episodes mix masked and allowed bits against a bench model.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   typedef enum logic [1:0] {
      PM_RUN   = 2'd0,
      PM_SLEEP = 2'd1,
      PM_STOP  = 2'd2,
      PM_STBY  = 2'd3
   } pm_mode_e;

   localparam int WAKE_W  = 11;
   localparam int WK_IRQ  = 0;
   localparam int WK_EXTI = 1;
   localparam int WK_AUTO = 2;
   localparam int WK_RTMR = 3;
   localparam int WK_WDOG = 4;
   localparam int WK_RTC  = 5;
   localparam int WK_TAMP = 6;
   localparam int WK_PIN  = 7;
   localparam int WK_XRST = 8;
   localparam int WK_BOR  = 9;
   localparam int WK_CSS  = 10;

   // which wake bit may end a given low-power mode
   function automatic logic wake_allowed(input int idx, input pm_mode_e m,
                                         input logic deep, input logic keep_radio);
      logic ok;
      ok = 1'b0;
      if (m == PM_SLEEP) begin
         ok = 1'b1;
      end else if (m == PM_STOP) begin
         if (idx == WK_IRQ)      ok = 1'b0;
         else if (idx == WK_CSS) ok = ~deep;
         else                    ok = 1'b1;
      end else if (m == PM_STBY) begin
         if (idx >= WK_WDOG && idx <= WK_BOR) ok = 1'b1;
         else if (idx == WK_RTMR)             ok = keep_radio;
         else                                 ok = 1'b0;
      end
      return ok;
   endfunction
endpackage

// File: rtl/pmc_stop_sel.sv
module pmc_stop_sel #(
   parameter int N_KER  = 4,
   parameter int N_AUTO = 2
) (
   input  logic [N_KER-1:0]  kern_req,
   input  logic [N_AUTO-1:0] auto_req,
   output logic              deep_ok
);
   if (N_KER < 1 || N_AUTO < 1) begin : g_bad_cfg
      $error("pmc_stop_sel: N_KER and N_AUTO must be at least 1");
   end

   // deep stop only when no clock consumer remains
   assign deep_ok = ~(|kern_req) & ~(|auto_req);
endmodule

// File: rtl/pmc_wake_mask.sv
module pmc_wake_mask
   import pmc_pkg::*;
#(
   parameter int W = WAKE_W
) (
   input  pm_mode_e     mode,
   input  logic         deep,
   input  logic         keep_radio,
   output logic [W-1:0] mask
);
   if (W != WAKE_W) begin : g_bad_w
      $error("pmc_wake_mask: W must equal WAKE_W");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign mask[i] = wake_allowed(i, mode, deep, keep_radio);
   end
endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
   import pmc_pkg::*;
#(
   parameter int W = WAKE_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         enter,
   input  logic [1:0]   req,
   input  logic         deep_ok,
   input  logic         ll_ds,
   input  logic [1:0]   keep_sram_in,
   input  logic         keep_radio_in,
   input  logic [W-1:0] hit,
   output pm_mode_e     mode,
   output logic         deep,
   output logic [1:0]   keep_sram,
   output logic         keep_radio,
   output logic         downgrade,
   output logic [W-1:0] cause,
   output logic         hsi,
   output logic         rst_req
);
   logic     take;
   logic     any_hit;
   pm_mode_e target;

   assign take    = (mode == PM_RUN) && enter && (req != 2'd0);
   assign any_hit = (mode != PM_RUN) && (|hit);

   always_comb begin
      target = pm_mode_e'(req);
      if (req == 2'd3 && !ll_ds) target = PM_STOP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode       <= PM_RUN;
         deep       <= 1'b0;
         keep_sram  <= '0;
         keep_radio <= 1'b0;
         downgrade  <= 1'b0;
         cause      <= '0;
         hsi        <= 1'b0;
         rst_req    <= 1'b0;
      end else begin
         rst_req <= 1'b0;
         if (take) begin
            mode       <= target;
            deep       <= deep_ok;
            keep_sram  <= keep_sram_in;
            keep_radio <= keep_radio_in;
            if (req == 2'd3 && !ll_ds) downgrade <= 1'b1;
         end else if (any_hit) begin
            mode    <= PM_RUN;
            cause   <= hit;
            hsi     <= (mode != PM_SLEEP);
            rst_req <= (mode == PM_STBY);
         end
      end
   end

   p_stby_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_RUN && enter && req == 2'd3 && !ll_ds) |=> (mode == PM_STOP && downgrade));
   p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      downgrade |=> downgrade);
   p_wake_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != PM_RUN && |hit) |=> (mode == PM_RUN));
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != PM_RUN && hit == '0) |=> $stable(mode));
   p_rst_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);
   p_rst_stby_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_STBY && |hit) |=> rst_req);
   p_hsi_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_STOP && |hit) |=> (hsi && !rst_req));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int N_KER  = 4,
   parameter int N_AUTO = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lp_enter,
   input  logic [1:0]        lp_req,
   input  logic [1:0]        lp_keep_sram,
   input  logic              lp_keep_radio,
   input  logic [N_KER-1:0]  kern_clk_req,
   input  logic [N_AUTO-1:0] auto_bus_req,
   input  logic              ll_deep_sleep,
   input  logic [10:0]       wake_src,
   output logic [1:0]        mode,
   output logic              stop_deep,
   output logic              cpu_clk_en,
   output logic              sys_clk_en,
   output logic              hs_osc_en,
   output logic              bus_clk_en,
   output logic              core_pwr_en,
   output logic [1:0]        sram_ret,
   output logic              radio_ret,
   output logic              downgrade,
   output logic [10:0]       wake_cause,
   output logic              wake_clk_hsi,
   output logic              reset_req
);
   localparam int W = WAKE_W;

   pm_mode_e     cur;
   logic         deep_ok, deep_r, keep_radio_r;
   logic [1:0]   keep_sram_r;
   logic [W-1:0] mask, hit;
   logic [4:0]   en;

   pmc_stop_sel #(.N_KER(N_KER), .N_AUTO(N_AUTO)) u_sel (
      .kern_req(kern_clk_req), .auto_req(auto_bus_req), .deep_ok(deep_ok));

   pmc_wake_mask #(.W(W)) u_mask (
      .mode(cur), .deep(deep_r), .keep_radio(keep_radio_r), .mask(mask));

   assign hit = wake_src & mask;

   pmc_seq #(.W(W)) u_seq (
      .clk(clk), .rst_n(rst_n), .enter(lp_enter), .req(lp_req),
      .deep_ok(deep_ok), .ll_ds(ll_deep_sleep),
      .keep_sram_in(lp_keep_sram), .keep_radio_in(lp_keep_radio),
      .hit(hit), .mode(cur), .deep(deep_r), .keep_sram(keep_sram_r),
      .keep_radio(keep_radio_r), .downgrade(downgrade), .cause(wake_cause),
      .hsi(wake_clk_hsi), .rst_req(reset_req));

   always_comb begin
      unique case (cur)
         PM_RUN:   en = 5'b11111;
         PM_SLEEP: en = 5'b01111;
         PM_STOP:  en = deep_r ? 5'b00001 : 5'b00011;
         default:  en = 5'b00000;
      endcase
   end

   assign {cpu_clk_en, sys_clk_en, hs_osc_en, bus_clk_en, core_pwr_en} = en;
   assign mode      = cur;
   assign stop_deep = (cur == PM_STOP) && deep_r;
   assign sram_ret  = (cur == PM_STBY) ? keep_sram_r : 2'b00;
   assign radio_ret = (cur == PM_STBY) && keep_radio_r;

   p_run_only_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cur != PM_RUN && (wake_src & mask) == '0) |=> (mode == $past(mode)));
   p_no_reset_from_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == PM_SLEEP) |=> !reset_req);
   p_stby_needs_ll_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == PM_RUN && lp_enter && lp_req == 2'd3) |=> (cur == PM_STBY) == $past(ll_deep_sleep));
endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
   localparam int NK = 4;
   localparam int NA = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic lp_enter = 1'b0, lp_keep_radio = 1'b0, ll_deep_sleep = 1'b0;
   logic [1:0] lp_req = '0, lp_keep_sram = '0;
   logic [NK-1:0] kern_clk_req = '0;
   logic [NA-1:0] auto_bus_req = '0;
   logic [10:0] wake_src = '0;
   logic [1:0] mode, sram_ret;
   logic stop_deep, cpu_clk_en, sys_clk_en, hs_osc_en, bus_clk_en, core_pwr_en;
   logic radio_ret, downgrade, wake_clk_hsi, reset_req;
   logic [10:0] wake_cause;

   int checks = 0, fails = 0;
   bit done = 0;

   // bench model
   int m_mode = 0; bit m_deep = 0, m_kr = 0, m_down = 0, m_hsi = 0, m_rst = 0;
   logic [1:0] m_ks = 0; logic [10:0] m_cause = 0;

   always #2 clk = ~clk;

   pwr_mode_ctrl #(.N_KER(NK), .N_AUTO(NA)) uut (.*);

   function automatic logic [10:0] allow(int md, bit dp, bit kr);
      logic [10:0] a = '0;
      if (md == 1) a = 11'h7FF;
      else if (md == 2) a = dp ? 11'h3FE : 11'h7FE;
      else if (md == 3) a = 11'h3F0 | (kr ? 11'h008 : 11'h000);
      return a;
   endfunction

   function automatic logic [4:0] exp_en(int md, bit dp);
      if (md == 0) return 5'b11111;
      if (md == 1) return 5'b01111;
      if (md == 2) return dp ? 5'b00001 : 5'b00011;
      return 5'b00000;
   endfunction

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all();
      chk("R2 mode", 16'(mode), 16'(m_mode));
      chk("R3 stop_deep", 16'(stop_deep), 16'(m_mode == 2 && m_deep));
      chk("R9 enables", 16'({cpu_clk_en, sys_clk_en, hs_osc_en, bus_clk_en, core_pwr_en}),
          16'(exp_en(m_mode, m_deep)));
      chk("R10 sram_ret", 16'(sram_ret), 16'(m_mode == 3 ? m_ks : 2'b00));
      chk("R10 radio_ret", 16'(radio_ret), 16'(m_mode == 3 && m_kr));
      chk("R4 R11 downgrade", 16'(downgrade), 16'(m_down));
      chk("R6 wake_cause", 16'(wake_cause), 16'(m_cause));
      chk("R7 wake_clk_hsi", 16'(wake_clk_hsi), 16'(m_hsi));
      chk("R8 reset_req", 16'(reset_req), 16'(m_rst));
   endtask

   // one clock: model next state from driven inputs, then compare after the edge
   task automatic cyc();
      logic [10:0] h;
      int nm = m_mode;
      m_rst = 0;
      if (m_mode == 0) begin
         if (lp_enter && lp_req != 0) begin
            nm = lp_req;
            if (lp_req == 3 && !ll_deep_sleep) begin nm = 2; m_down = 1; end
            m_deep = !((|kern_clk_req) || (|auto_bus_req));
            m_ks = lp_keep_sram; m_kr = lp_keep_radio;
         end
      end else begin
         h = wake_src & allow(m_mode, m_deep, m_kr);
         if (h != 0) begin
            m_cause = h; m_hsi = (m_mode != 1); m_rst = (m_mode == 3); nm = 0;
         end
      end
      @(posedge clk); #1;
      m_mode = nm;
      check_all();
   endtask

   task automatic enter_mode(int rq, bit ll, logic [NK-1:0] kr, logic [NA-1:0] ar,
                             logic [1:0] ks, bit krad, logic [10:0] ws);
      lp_req = 2'(rq); ll_deep_sleep = ll; kern_clk_req = kr; auto_bus_req = ar;
      lp_keep_sram = ks; lp_keep_radio = krad; wake_src = ws; lp_enter = 1;
      cyc();
      lp_enter = 0;
   endtask

   task automatic wake(logic [10:0] ws);
      wake_src = ws; cyc(); wake_src = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED));
      #1; check_all();                       // R1 during reset
      repeat (2) @(posedge clk);
      #1; rst_n = 1;
      cyc();
      chk("R1 reset mode run", 16'(mode), 16'd0);
      chk("R1 reset enables", 16'({cpu_clk_en, sys_clk_en, hs_osc_en, bus_clk_en, core_pwr_en}), 16'h1F);

      // R2: req 0 ignored
      enter_mode(0, 1, 0, 0, 0, 0, 0);
      chk("R2 req0 ignored", 16'(mode), 16'd0);
      // sleep, wake by generic irq (bit0, allowed only in sleep) R5 R7
      enter_mode(1, 1, 0, 0, 0, 0, 0);
      lp_enter = 1; lp_req = 3; cyc(); lp_enter = 0;
      chk("R2 strobe in sleep ignored", 16'(mode), 16'd1);
      wake(11'h001);
      chk("R5 irq wakes sleep", 16'(mode), 16'd0);
      chk("R7 sleep keeps clock", 16'(wake_clk_hsi), 16'd0);
      // deep stop: irq and css masked, rtc wakes
      enter_mode(2, 1, 0, 0, 0, 0, 0);
      chk("R3 deep stop", 16'(stop_deep), 16'd1);
      wake(11'h401); wake(11'h401);
      chk("R5 css masked in deep stop", 16'(mode), 16'd2);
      wake(11'h020);
      chk("R7 stop wake uses hsi", 16'(wake_clk_hsi), 16'd1);
      // light stop via auto bus request, css wakes
      enter_mode(2, 1, 0, 2'b10, 0, 0, 0);
      chk("R3 light stop", 16'(stop_deep), 16'd0);
      wake(11'h400);
      chk("R6 cause css", 16'(wake_cause), 16'h400);
      // standby without radio retention: radio timer masked
      enter_mode(3, 1, 0, 0, 2'b01, 0, 0);
      wake(11'h008);
      chk("R5 radio timer masked in plain standby", 16'(mode), 16'd3);
      wake(11'h200);
      chk("R8 reset on standby exit", 16'(reset_req), 16'd1);
      cyc();
      chk("R8 reset single pulse", 16'(reset_req), 16'd0);
      // standby with retention, radio timer wakes
      enter_mode(3, 1, 0, 0, 2'b11, 1, 0);
      chk("R10 sram kept", 16'(sram_ret), 16'd3);
      wake(11'h008);
      chk("R5 radio timer wakes retained standby", 16'(mode), 16'd0);
      // same cycle: refused standby + radio timer held at entry
      enter_mode(3, 0, 0, 0, 2'b11, 1, 11'h008);
      chk("R4 downgrade to stop", 16'(mode), 16'd2);
      cyc(); wake_src = 0;
      chk("R6 wake next cycle after downgrade", 16'(mode), 16'd0);
      chk("R8 no reset from stop", 16'(reset_req), 16'd0);
      chk("R11 downgrade sticky", 16'(downgrade), 16'd1);

      // random episodes
      for (int ep = 0; ep < 1500; ep++) begin
         int idle = $urandom_range(0, 2);
         for (int k = 0; k < idle; k++) begin
            wake_src = 11'($urandom); cyc();
         end
         enter_mode($urandom_range(0, 3), ($urandom_range(0, 3) != 0),
                    ($urandom_range(0, 2) == 0) ? NK'($urandom) : '0,
                    ($urandom_range(0, 3) == 0) ? NA'($urandom) : '0,
                    2'($urandom), 1'($urandom), 11'($urandom));
         wake_src = 0;
         for (int k = 0; k < 8 && m_mode != 0; k++) begin
            lp_enter = 1'($urandom); lp_req = 2'($urandom);
            wake_src = ($urandom_range(0, 2) == 0) ? (11'd1 << $urandom_range(0, 10)) : 11'd0;
            cyc();
         end
         lp_enter = 0;
         if (m_mode != 0) wake(11'h200);
      end

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule